// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects up to 28 level-sensitive interrupt request lines, masks them with a per-source enable register, and picks one winner. Each source has a 3-bit urgency level. The winner's 5-bit index is combined with a programmable 16-bit table base to form a word-aligned vector address. That address selects one of 32 handler pointers in a table outside the block. A single IRQ line tells the core that an enabled request is pending.

Software reaches the block through a plain 32-bit register port with a byte offset, a write strobe, write data and combinational read data. Every access is accepted in the cycle it is presented, so the port has no back-pressure: a write takes effect at the next rising clock edge, and a read returns data in the same cycle. The request lines are sampled on every clock. The winner and the IRQ line are recomputed from them combinationally and registered once per cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads zero, irq_o is low and vec_o is zero.
- R2: The table base sits at offset 0x14 in bits 15:0. Bits 31:16 always read zero.
- R3: The vector reads as bits 22:7 = base, bits 6:2 = winning index, and bits 1:0 and 31:23 = zero. It appears on vec_o and at offset 0x1C, and writes to 0x1C are ignored.
- R4: Urgency bank A, at offset 0x20, holds source s (s = 1..7) at bits 4s+2:4s. Source 1 is the software interrupt, sources 2..6 are timers 0..4 (timer 2 is index 4) and source 7 is the output fault. Bits 3:0 and every bit 4s+3 read zero.
- R5: Urgency bank B, at offset 0x24, holds source 8+n at bits 4n+2:4n for n = 0 and n = 2..7. Bits 7:3 and every bit 4n+3 read zero. Sources 0, 9 and 16..27 have a fixed level of 7.
- R6: Level 0 is the most urgent and level 7 the least. Among active enabled sources, the lowest level wins.
- R7: When active sources share the winning level, the lower index wins.
- R8: The enable register sits at offset 0x00, with bit i enabling source i over bits 27:0. A disabled request neither raises irq_o nor wins.
- R9: irq_o and the winning index are registered. They reflect the requests and registers of the previous rising edge, one cycle after a change.
- R10: The control register sits at offset 0x04 and holds the nesting enable in bit 0. When that bit is clear, or when no enabled source is active, the index field of the vector reads zero.
- R11: Offsets outside the map read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | input | 28 | Level-sensitive request lines |
| irq_o | output | 1 | Enabled request pending (registered) |
| vec_o | output | 32 | Vector address into the handler table |

## Verification
On every cycle, the assertions check the following:
- the constant-zero vector fields;
- that the index field is suppressed while nesting is off;
- the one-cycle link between enabled requests and irq_o;
- that reserved urgency bits never hold ones;
- that the arbiter's winner is really an active source.

Only the bench scenarios can show that the chosen source is the right one: the lowest level winning across both banks, ties going to the lower index, and fixed-level sources losing to programmed ones. The same holds for the exact field positions of each register as seen through reads.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_SRC  = 28;
  localparam int PRIO_W   = 3;
  localparam int BASE_W   = 16;
  localparam int IDX_W    = 5;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int PROG_SRC = 16;

  localparam logic [ADDR_W-1:0] OFF_EN    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_BASE  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_VEC   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_PRIOA = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_PRIOB = 8'h24;

  // sources 0..15 with a programmable nibble (0 and 9 are fixed)
  localparam logic [PROG_SRC-1:0] PROG_MASK = 16'b1111_1101_1111_1110;

  function automatic logic [DATA_W-1:0] bank_mask(input int bank);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < 8; n++)
      if (PROG_MASK[bank*8+n]) m[4*n +: PRIO_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] PRIOA_MASK = bank_mask(0);
  localparam logic [DATA_W-1:0] PRIOB_MASK = bank_mask(1);

  typedef logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr_t;
endpackage

// File: rtl/irqv_regfile.sv
module irqv_regfile
  import irqv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [NUM_SRC-1:0]  en_q,
  output logic                nest_q,
  output logic [BASE_W-1:0]   base_q,
  output logic [DATA_W-1:0]   prioa_q,
  output logic [DATA_W-1:0]   priob_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      nest_q  <= 1'b0;
      base_q  <= '0;
      prioa_q <= '0;
      priob_q <= '0;
    end else if (bus_we) begin
      unique case (bus_addr)
        OFF_EN:    en_q    <= bus_wdata[NUM_SRC-1:0];
        OFF_CTRL:  nest_q  <= bus_wdata[0];
        OFF_BASE:  base_q  <= bus_wdata[BASE_W-1:0];
        OFF_PRIOA: prioa_q <= bus_wdata & PRIOA_MASK;
        OFF_PRIOB: priob_q <= bus_wdata & PRIOB_MASK;
        default: ;
      endcase
    end
  end

  assert_prioa_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prioa_q & ~PRIOA_MASK) == '0);
  assert_priob_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (priob_q & ~PRIOB_MASK) == '0);
  assert_base_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == OFF_BASE) |=> $stable(base_q));
  assert_unmapped_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h40) |=> ($stable(en_q) && $stable(prioa_q) && $stable(priob_q)));
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] act,
  input  prio_arr_t          prio,
  output logic               found,
  output logic [IDX_W-1:0]   win_idx
);
  logic [PRIO_W-1:0] best_p;

  // strict "<" keeps the lowest index among equal levels
  always_comb begin
    found   = 1'b0;
    best_p  = '1;
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act[i] && (!found || prio[i] < best_p)) begin
        found   = 1'b1;
        best_p  = prio[i];
        win_idx = IDX_W'(i);
      end
    end
  end

  assert_winner_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> act[win_idx]);
  assert_none_found_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> ($countones(act) == 0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0]  irq_req,
  output logic                irq_o,
  output logic [DATA_W-1:0]   vec_o
);
  logic [NUM_SRC-1:0] en_q;
  logic               nest_q;
  logic [BASE_W-1:0]  base_q;
  logic [DATA_W-1:0]  prioa_q, priob_q;
  logic [NUM_SRC-1:0] act;
  prio_arr_t          prio;
  logic               found;
  logic [IDX_W-1:0]   win_idx, idx_q;
  logic               irq_q;
  logic [IDX_W-1:0]   idx_field;
  logic [2*DATA_W-1:0] prio_cat;

  irqv_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .en_q(en_q), .nest_q(nest_q), .base_q(base_q),
    .prioa_q(prioa_q), .priob_q(priob_q)
  );

  assign prio_cat = {priob_q, prioa_q};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    if (i < PROG_SRC && PROG_MASK[i]) begin : g_prog
      assign prio[i] = prio_cat[4*i +: PRIO_W];
    end else begin : g_fixed
      assign prio[i] = '1;
    end
  end

  assign act = irq_req & en_q;

  irqv_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .act(act), .prio(prio),
    .found(found), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= found;
      idx_q <= win_idx;
    end
  end

  assign irq_o     = irq_q;
  assign idx_field = (nest_q && irq_q) ? idx_q : '0;
  assign vec_o     = DATA_W'({base_q, idx_field, 2'b00});

  always_comb begin
    unique case (bus_addr)
      OFF_EN:    bus_rdata = DATA_W'(en_q);
      OFF_CTRL:  bus_rdata = DATA_W'(nest_q);
      OFF_BASE:  bus_rdata = DATA_W'(base_q);
      OFF_VEC:   bus_rdata = vec_o;
      OFF_PRIOA: bus_rdata = prioa_q;
      OFF_PRIOB: bus_rdata = priob_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|act) |=> irq_o);
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|act) |=> !irq_o);
  assert_vec_zero_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o[1:0] == 2'b00 && vec_o[31:23] == '0);
  assert_idx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_q || !irq_o) |-> vec_o[6:2] == '0);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [27:0] irq_req = '0;
  logic        irq_o;
  logic [31:0] vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  typedef struct packed {
    logic [27:0] req;
    logic [27:0] en;
    logic [31:0] pa;
    logic [31:0] pb;
    logic        nest;
    logic        eirq;
    logic [4:0]  eidx;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{28'h0000010, 28'hFFFFFFF, 32'h0, 32'h0,          1'b1, 1'b1, 5'd4},  // R3 timer 2 alone
    '{28'h0000014, 28'hFFFFFFF, 32'h0, 32'h0,          1'b1, 1'b1, 5'd2},  // R7 tie
    '{28'h0000014, 28'hFFFFFFF, 32'h500, 32'h0,        1'b1, 1'b1, 5'd4},  // R6 level
    '{28'h0100100, 28'hFFFFFFF, 32'h0, 32'h0,          1'b1, 1'b1, 5'd8},  // R5 fixed loses
    '{28'h0100001, 28'hFFFFFFF, 32'h0, 32'h0,          1'b1, 1'b1, 5'd0},  // R7 fixed tie
    '{28'h0000010, 28'hFFFFFEF, 32'h0, 32'h0,          1'b1, 1'b0, 5'd0},  // R8 masked
    '{28'h0001010, 28'hFFFFFFF, 32'h0, 32'h0,          1'b0, 1'b1, 5'd4},  // R10 nest off
    '{28'h0001800, 28'hFFFFFFF, 32'h0, 32'h00023000,   1'b1, 1'b1, 5'd12}, // R6 bank B
    '{28'h0000000, 28'hFFFFFFF, 32'h0, 32'h0,          1'b1, 1'b0, 5'd0},  // R10 idle
    '{28'h8008000, 28'hFFFFFFF, 32'h0, 32'h70000000,   1'b1, 1'b1, 5'd15}  // R7 level 7 tie
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  function automatic logic [31:0] exp_vec(input logic [15:0] b, input logic [4:0] i,
                                          input logic nest, input logic irq);
    return {9'b0, b, (nest && irq) ? i : 5'd0, 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 vec", vec_o, 32'h0);
    rd_check("R1 en", 8'h00, 32'h0);
    rd_check("R1 ctrl", 8'h04, 32'h0);
    rd_check("R1 base", 8'h14, 32'h0);
    rd_check("R1 prioA", 8'h20, 32'h0);
    rd_check("R1 prioB", 8'h24, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // register layouts
    wr(8'h14, 32'hFFFF_ABCD); rd_check("R2 base upper zero", 8'h14, 32'h0000_ABCD);
    wr(8'h20, 32'hFFFF_FFFF); rd_check("R4 bank A layout", 8'h20, 32'h7777_7770);
    wr(8'h24, 32'hFFFF_FFFF); rd_check("R5 bank B layout", 8'h24, 32'h7777_7707);
    wr(8'h00, 32'hFFFF_FFFF); rd_check("R8 enable width", 8'h00, 32'h0FFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF); rd_check("R10 ctrl bit", 8'h04, 32'h0000_0001);
    wr(8'h40, 32'hFFFF_FFFF); rd_check("R11 unmapped read", 8'h40, 32'h0);
    rd_check("R11 base kept", 8'h14, 32'h0000_ABCD);
    wr(8'h1C, 32'hFFFF_FFFF); rd_check("R3 vector write ignored", 8'h1C, exp_vec(16'hABCD, 5'd0, 1'b1, 1'b0));

    // R9 latency with all sources at level 7 (bank all ones masked to 7)
    irq_req = 28'h0000020;
    #1;
    check("R9 irq not yet", 32'(irq_o), 32'h0);
    @(negedge clk);
    check("R9 irq registered", 32'(irq_o), 32'h1);
    check("R9 vec registered", vec_o, exp_vec(16'hABCD, 5'd5, 1'b1, 1'b1));
    irq_req = '0;
    @(negedge clk);
    check("R9 irq drop", 32'(irq_o), 32'h0);

    wr(8'h14, 32'h0000_1234);
    for (int k = 0; k < NV; k++) begin
      irq_req = TBL[k].req;
      wr(8'h00, 32'(TBL[k].en));
      wr(8'h20, TBL[k].pa);
      wr(8'h24, TBL[k].pb);
      wr(8'h04, 32'(TBL[k].nest));
      @(negedge clk);
      check($sformatf("R8/R9 irq vector %0d", k), 32'(irq_o), 32'(TBL[k].eirq));
      check($sformatf("R6/R7/R10 vec vector %0d", k), vec_o,
            exp_vec(16'h1234, TBL[k].eidx, TBL[k].nest, TBL[k].eirq));
      rd_check($sformatf("R3 vec read vector %0d", k), 8'h1C,
               exp_vec(16'h1234, TBL[k].eidx, TBL[k].nest, TBL[k].eirq));
    end

    // R8 disabling a pending source takes effect
    irq_req = 28'h0000010;
    wr(8'h00, 32'h0FFF_FFFF);
    @(negedge clk);
    check("R8 enabled pending", 32'(irq_o), 32'h1);
    wr(8'h00, 32'h0);
    @(negedge clk);
    check("R8 disabled drops irq", 32'(irq_o), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule